// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block places received frames into a circular ring of buffer descriptors. A MAC delivers one byte per cycle, and the block writes each byte into the data buffer of the current descriptor. When the frame ends, the block writes the length and the completion flags into that descriptor, clears its EMPTY flag and moves the ring pointer on. The ring closes through a WRAP flag carried only by the last descriptor, so the pointer goes back to entry 0 after that entry is used.

Software gives descriptors back through a small register port. It can read any descriptor's flags and length. It can free a descriptor with a pulse, which sets EMPTY and zeroes the length. A sticky frame event, cleared by writing 1, reports each completed descriptor.

Receive is off after reset and starts on an enable pulse. If a frame begins while the current descriptor is not EMPTY, the block stalls and drops the input. It stays stalled until software frees descriptors and sends another enable pulse.

The controller has five states:
- `ST_OFF`: the state after reset.
- `ST_IDLE`: waiting for the first byte of a frame.
- `ST_FILL`: writing a frame.
- `ST_DROP`: discarding the tail of a frame that overran its buffer.
- `ST_STALL`: receive stopped.

The transitions are:
- OFF→IDLE on an enable pulse.
- IDLE→FILL on a frame start into an EMPTY descriptor, when that byte is not the end of the frame.
- IDLE→STALL on a frame start into a descriptor that is not EMPTY.
- FILL→IDLE at the end of the frame.
- FILL→DROP on an overrun that is not the end of the frame.
- FILL→IDLE on an overrun that is also the end of the frame.
- DROP→IDLE at the end of the frame.
- STALL→IDLE on an enable pulse.

Top module: `rxring_rx_mgr`

## Requirements
- R1: After reset, `ring_idx` is 0. Every descriptor reads EMPTY=1, LAST=0, ERR=0 and length 0, and only entry DEPTH-1 reads WRAP=1. `busy`, `stalled` and `frame_evt` are 0. No buffer write happens until the first `sw_enable` pulse.
- R2: A frame starting on an EMPTY current descriptor is written to that descriptor (`buf_sel`). Byte k goes to `buf_addr` k. `busy` is 1 from the cycle after the first byte until the frame ends.
- R3: On completion the descriptor reads EMPTY=0 and LAST=1. Its length is the number of bytes received, including the 4-byte FCS. ERR equals `rx_err` on the final byte.
- R4: Each completion advances `ring_idx` by one. After the WRAP descriptor has been used, `ring_idx` returns to 0.
- R5: A frame longer than BUF_BYTES writes only BUF_BYTES bytes. It completes with length BUF_BYTES, LAST=1 and ERR=1. The rest of the frame is discarded, and the next frame goes to the next descriptor starting at address 0.
- R6: A frame start on a descriptor that is not EMPTY sets `stalled`. While stalled, no byte is written and no descriptor changes, even after software frees entries. This holds until an `sw_enable` pulse.
- R7: An `sw_enable` pulse while stalled clears `stalled` and keeps the ring index. The rest of the frame that was dropped is not stored. The next frame start fills the current descriptor.
- R8: An `sw_enable` pulse while `busy` is 1 is ignored, and the frame completes unchanged.
- R9: An `sw_free` pulse sets EMPTY, clears LAST and ERR and sets the length to 0 on the descriptor `sw_free_idx`. WRAP is left unchanged.
- R10: `frame_evt` becomes 1 after each completion and stays 1 until an `sw_evt_clr` pulse. If a completion and a clear happen in the same cycle, the completion wins.
- R11: `sw_rd_good` is 1 exactly when the descriptor that is read has LAST=1, ERR=0 and a length greater than 18, that is, more than 14 bytes without the FCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_sel | output | IDX_W | Descriptor whose buffer is written |
| buf_addr | output | AW | Byte offset in the buffer |
| buf_wdata | output | 8 | Byte to write |
| sw_free | input | 1 | Free-descriptor pulse |
| sw_free_idx | input | IDX_W | Descriptor to free |
| sw_enable | input | 1 | Receive enable pulse |
| sw_evt_clr | input | 1 | Write-1 clear of the frame event |
| sw_rd_idx | input | IDX_W | Descriptor to read |
| sw_rd_empty | output | 1 | EMPTY flag of the descriptor read |
| sw_rd_wrap | output | 1 | WRAP flag of the descriptor read |
| sw_rd_last | output | 1 | LAST flag of the descriptor read |
| sw_rd_err | output | 1 | ERR flag of the descriptor read |
| sw_rd_len | output | LEN_W | Length of the descriptor read |
| sw_rd_good | output | 1 | Descriptor holds a usable frame |
| ring_idx | output | IDX_W | Current ring position |
| busy | output | 1 | A descriptor is being filled |
| stalled | output | 1 | Receive stopped, waiting for enable |
| frame_evt | output | 1 | Sticky frame-received event |

## Verification
The assertions check on every cycle four behaviours:
- A completion targets only an EMPTY descriptor.
- A completed length is never 0 and never above the buffer size.
- The ring index only steps by one or returns to 0, and a stall holds until an enable pulse.
- Each completion raises the event.

The bench scenarios show the behaviours that depend on a whole frame:
- Byte counts including the FCS, error propagation and the length rule for a usable frame.
- Discarding after an overrun, and wrapping through the ring.
- Ignoring the tail of a dropped frame after a re-enable, and ignoring an enable during a frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_FILL,
        ST_DROP,
        ST_STALL
    } rxr_state_e;

    typedef struct packed {
        logic empty;
        logic wrap;
        logic last;
        logic err;
    } rxr_flags_t;

endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MAX_LEN = 1518,
    parameter int IDX_W   = 2,
    parameter int LEN_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic [LEN_W-1:0] cmp_len,
    input  logic             cmp_err,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             cur_empty,
    output logic             cur_wrap,
    output rxr_flags_t       rd_flags,
    output logic [LEN_W-1:0] rd_len
);

    rxr_flags_t       flags_q [DEPTH];
    logic [LEN_W-1:0] len_q   [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                flags_q[i] <= '{empty: 1'b1, wrap: (i == DEPTH - 1), last: 1'b0, err: 1'b0};
                len_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmp_en && cmp_idx == IDX_W'(i)) begin
                    flags_q[i].empty <= 1'b0;
                    flags_q[i].last  <= 1'b1;
                    flags_q[i].err   <= cmp_err;
                    len_q[i]         <= cmp_len;
                end else if (free_en && free_idx == IDX_W'(i)) begin
                    flags_q[i].empty <= 1'b1;
                    flags_q[i].last  <= 1'b0;
                    flags_q[i].err   <= 1'b0;
                    len_q[i]         <= '0;
                end
            end
        end
    end

    always_comb begin
        cur_empty = flags_q[cur_idx].empty;
        cur_wrap  = flags_q[cur_idx].wrap;
        rd_flags  = flags_q[rd_idx];
        rd_len    = len_q[rd_idx];
    end

    // R3
    fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> flags_q[cmp_idx].empty);

    // R5
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (cmp_len != '0 && cmp_len <= LEN_W'(MAX_LEN)));

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1518,
    parameter int IDX_W     = 2,
    parameter int LEN_W     = 11,
    parameter int AW        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic             sw_enable,
    input  logic             cur_empty,
    input  logic             cur_wrap,
    output logic             buf_we,
    output logic [AW-1:0]    buf_addr,
    output logic             cmp_en,
    output logic [LEN_W-1:0] cmp_len,
    output logic             cmp_err,
    output logic [IDX_W-1:0] ring_idx,
    output logic             busy,
    output logic             stalled
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BUF_BYTES);

    rxr_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             mid_q;
    logic             start;
    logic             overrun;

    assign start   = rx_valid && !mid_q;
    assign overrun = (cnt_q == FULL_LEN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            idx_q   <= '0;
            mid_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            if (rx_valid)
                mid_q <= !rx_eof;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (sw_enable)
                    state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (start) begin
                    if (!cur_empty) begin
                        state_d = ST_STALL;
                    end else if (!rx_eof) begin
                        state_d = ST_FILL;
                        cnt_d   = LEN_W'(1);
                    end
                end
            end
            ST_FILL: begin
                if (rx_valid) begin
                    if (overrun)
                        state_d = rx_eof ? ST_IDLE : ST_DROP;
                    else if (rx_eof)
                        state_d = ST_IDLE;
                    else
                        cnt_d = cnt_q + LEN_W'(1);
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_eof)
                    state_d = ST_IDLE;
            end
            ST_STALL: begin
                if (sw_enable)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        buf_we   = 1'b0;
        buf_addr = AW'(cnt_q);
        cmp_en   = 1'b0;
        cmp_len  = cnt_q + LEN_W'(1);
        cmp_err  = rx_err;
        unique case (state_q)
            ST_IDLE: begin
                if (start && cur_empty) begin
                    buf_we   = 1'b1;
                    buf_addr = '0;
                    cmp_en   = rx_eof;
                    cmp_len  = LEN_W'(1);
                end
            end
            ST_FILL: begin
                if (rx_valid) begin
                    if (overrun) begin
                        cmp_en  = 1'b1;
                        cmp_len = FULL_LEN;
                        cmp_err = 1'b1;
                    end else begin
                        buf_we = 1'b1;
                        cmp_en = rx_eof;
                    end
                end
            end
            default: ;
        endcase
        idx_d    = cmp_en ? (cur_wrap ? '0 : idx_q + IDX_W'(1)) : idx_q;
        ring_idx = idx_q;
        busy     = (state_q == ST_FILL);
        stalled  = (state_q == ST_STALL);
    end

    // R4
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_q) |-> (idx_q == '0 || idx_q == $past(idx_q) + IDX_W'(1)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !sw_enable) |=> stalled);

    // R6
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!buf_we && !cmp_en));

endmodule

// File: rtl/rxr_evt.sv
module rxr_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic evt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            evt_o <= 1'b0;
        else if (set_i)
            evt_o <= 1'b1;
        else if (clr_i)
            evt_o <= 1'b0;
    end

    // R10
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> evt_o);

endmodule

// File: rtl/rxring_rx_mgr.sv
module rxring_rx_mgr
    import rxr_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int BUF_BYTES = 1518,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int AW       = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_err,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_sel,
    output logic [AW-1:0]    buf_addr,
    output logic [7:0]       buf_wdata,
    input  logic             sw_free,
    input  logic [IDX_W-1:0] sw_free_idx,
    input  logic             sw_enable,
    input  logic             sw_evt_clr,
    input  logic [IDX_W-1:0] sw_rd_idx,
    output logic             sw_rd_empty,
    output logic             sw_rd_wrap,
    output logic             sw_rd_last,
    output logic             sw_rd_err,
    output logic [LEN_W-1:0] sw_rd_len,
    output logic             sw_rd_good,
    output logic [IDX_W-1:0] ring_idx,
    output logic             busy,
    output logic             stalled,
    output logic             frame_evt
);

    localparam logic [LEN_W-1:0] MIN_GOOD = LEN_W'(18);

    logic             cmp_en;
    logic [LEN_W-1:0] cmp_len;
    logic             cmp_err;
    logic             cur_empty;
    logic             cur_wrap;
    rxr_flags_t       rd_flags;

    rxr_ctrl #(
        .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W), .AW(AW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_err(rx_err),
        .sw_enable(sw_enable), .cur_empty(cur_empty), .cur_wrap(cur_wrap),
        .buf_we(buf_we), .buf_addr(buf_addr),
        .cmp_en(cmp_en), .cmp_len(cmp_len), .cmp_err(cmp_err),
        .ring_idx(ring_idx), .busy(busy), .stalled(stalled)
    );

    rxr_desc_table #(
        .DEPTH(DEPTH), .MAX_LEN(BUF_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .cmp_en(cmp_en), .cmp_idx(ring_idx), .cmp_len(cmp_len), .cmp_err(cmp_err),
        .free_en(sw_free), .free_idx(sw_free_idx),
        .cur_idx(ring_idx), .rd_idx(sw_rd_idx),
        .cur_empty(cur_empty), .cur_wrap(cur_wrap),
        .rd_flags(rd_flags), .rd_len(sw_rd_len)
    );

    rxr_evt i_evt (
        .clk(clk), .rst_n(rst_n),
        .set_i(cmp_en), .clr_i(sw_evt_clr), .evt_o(frame_evt)
    );

    assign buf_sel     = ring_idx;
    assign buf_wdata   = rx_data;
    assign sw_rd_empty = rd_flags.empty;
    assign sw_rd_wrap  = rd_flags.wrap;
    assign sw_rd_last  = rd_flags.last;
    assign sw_rd_err   = rd_flags.err;
    assign sw_rd_good  = rd_flags.last && !rd_flags.err && (sw_rd_len > MIN_GOOD);

endmodule

// File: tb/test_rxring_rx_mgr.sv
`timescale 1ns/1ps
module test_rxring_rx_mgr;

    localparam int DEPTH = 4;
    localparam int BUFB  = 1518;
    localparam int NV    = 6;
    localparam int V_LEN  [NV] = '{20, 18, 19, 5, 1520, 1518};
    localparam int V_ERR  [NV] = '{0, 0, 0, 1, 0, 0};
    localparam int V_XLEN [NV] = '{20, 18, 19, 5, 1518, 1518};
    localparam int V_XERR [NV] = '{0, 0, 0, 1, 1, 0};
    localparam int V_GOOD [NV] = '{1, 0, 1, 0, 0, 1};

    logic clk = 0;
    logic rst_n = 0;
    logic rx_valid = 0, rx_eof = 0, rx_err = 0;
    logic [7:0] rx_data = 0;
    logic sw_free = 0, sw_enable = 0, sw_evt_clr = 0;
    logic [1:0] sw_free_idx = 0, sw_rd_idx = 0;
    logic buf_we;
    logic [1:0] buf_sel;
    logic [10:0] buf_addr;
    logic [7:0] buf_wdata;
    logic sw_rd_empty, sw_rd_wrap, sw_rd_last, sw_rd_err, sw_rd_good;
    logic [10:0] sw_rd_len;
    logic [1:0] ring_idx;
    logic busy, stalled, frame_evt;

    int total = 0, fails = 0;
    int wr_count = 0, data_bad = 0, sel_bad = 0;
    int exp_idx = 0;
    logic [7:0] seed = 8'h5a;
    logic busy_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxring_rx_mgr #(.DEPTH(DEPTH), .BUF_BYTES(BUFB)) i_rxring_rx_mgr (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
        .buf_we(buf_we), .buf_sel(buf_sel), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .sw_free(sw_free), .sw_free_idx(sw_free_idx), .sw_enable(sw_enable),
        .sw_evt_clr(sw_evt_clr), .sw_rd_idx(sw_rd_idx),
        .sw_rd_empty(sw_rd_empty), .sw_rd_wrap(sw_rd_wrap), .sw_rd_last(sw_rd_last),
        .sw_rd_err(sw_rd_err), .sw_rd_len(sw_rd_len), .sw_rd_good(sw_rd_good),
        .ring_idx(ring_idx), .busy(busy), .stalled(stalled), .frame_evt(frame_evt)
    );

    // Buffer write monitor: byte k of a frame carries k ^ seed
    always @(posedge clk) begin
        if (buf_we) begin
            wr_count++;
            if (buf_wdata !== (buf_addr[7:0] ^ seed)) data_bad++;
            if (buf_sel !== 2'(exp_idx)) sel_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int n, input bit with_eof, input bit err, input int en_at);
        wr_count = 0; data_bad = 0; sel_bad = 0; busy_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 5) busy_seen = busy;
            rx_valid  = 1;
            rx_data   = 8'(i) ^ seed;
            rx_eof    = with_eof && (i == n - 1);
            rx_err    = err && (i == n - 1);
            sw_enable = (i == en_at);
        end
        @(negedge clk);
        rx_valid = 0; rx_eof = 0; rx_err = 0; sw_enable = 0;
    endtask

    task automatic pulse_enable();
        @(negedge clk); sw_enable = 1;
        @(negedge clk); sw_enable = 0;
    endtask

    task automatic free_desc(input int idx);
        @(negedge clk); sw_free = 1; sw_free_idx = 2'(idx);
        @(negedge clk); sw_free = 0;
    endtask

    task automatic clear_evt();
        @(negedge clk); sw_evt_clr = 1;
        @(negedge clk); sw_evt_clr = 0;
    endtask

    task automatic read_desc(input int idx);
        sw_rd_idx = 2'(idx);
        #0.5;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(ring_idx == 0 && !busy && !stalled && !frame_evt, "R1 idle", ring_idx, 0);
        for (int i = 0; i < DEPTH; i++) begin
            read_desc(i);
            check(sw_rd_empty && !sw_rd_last && !sw_rd_err && sw_rd_len == 0, "R1 desc clean", sw_rd_len, 0);
            check(sw_rd_wrap == (i == DEPTH - 1), "R1 wrap only last", sw_rd_wrap, i == DEPTH - 1);
        end
        // R1 no writes before enable
        send(10, 1, 0, -1);
        check(wr_count == 0, "R1 no write before enable", wr_count, 0);
        read_desc(0);
        check(sw_rd_empty && ring_idx == 0, "R1 desc untouched", sw_rd_empty, 1);
        pulse_enable();

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int wexp;
            wexp = (V_LEN[v] > BUFB) ? BUFB : V_LEN[v];
            send(V_LEN[v], 1, V_ERR[v][0], -1);
            check(wr_count == wexp, "R2/R5 write count", wr_count, wexp);
            check(data_bad == 0 && sel_bad == 0, "R2 byte placement", data_bad + sel_bad, 0);
            read_desc(exp_idx);
            check(!sw_rd_empty && sw_rd_last, "R3 flags", sw_rd_empty, 0);
            check(sw_rd_len == V_XLEN[v], "R3/R5 length", sw_rd_len, V_XLEN[v]);
            check(sw_rd_err == V_XERR[v][0], "R3/R5 err", sw_rd_err, V_XERR[v]);
            check(sw_rd_good == V_GOOD[v][0], "R11 good", sw_rd_good, V_GOOD[v]);
            exp_idx = (exp_idx == DEPTH - 1) ? 0 : exp_idx + 1;
            check(ring_idx == 2'(exp_idx), "R4 advance", ring_idx, exp_idx);
            check(frame_evt, "R10 event set", frame_evt, 1);
            clear_evt();
            check(!frame_evt, "R10 event clear", frame_evt, 0);
            free_desc((exp_idx + DEPTH - 1) % DEPTH);
            read_desc((exp_idx + DEPTH - 1) % DEPTH);
            check(sw_rd_empty && !sw_rd_last && !sw_rd_err && sw_rd_len == 0, "R9 free", sw_rd_len, 0);
            check(sw_rd_wrap == (((exp_idx + DEPTH - 1) % DEPTH) == DEPTH - 1), "R9 wrap kept", sw_rd_wrap, 0);
        end

        // R8 enable during fill ignored; R2 busy mid-frame
        send(30, 1, 0, 3);
        check(busy_seen == 1, "R2 busy during frame", busy_seen, 1);
        check(!busy, "R2 busy drops after end", busy, 0);
        read_desc(exp_idx);
        check(sw_rd_len == 30 && sw_rd_last, "R8 frame intact", sw_rd_len, 30);
        free_desc(exp_idx);
        exp_idx = (exp_idx + 1) % DEPTH;

        // R4 fill the whole ring without freeing
        for (int k = 0; k < DEPTH; k++) begin
            send(20, 1, 0, -1);
            exp_idx = (exp_idx + 1) % DEPTH;
        end
        check(ring_idx == 2'(exp_idx), "R4 wrap around", ring_idx, exp_idx);

        // R6 stall on a full descriptor
        send(4, 0, 0, -1);
        check(stalled, "R6 stalled", stalled, 1);
        check(wr_count == 0, "R6 no write", wr_count, 0);
        read_desc(exp_idx);
        check(!sw_rd_empty && sw_rd_len == 20, "R6 desc unchanged", sw_rd_len, 20);
        for (int k = 0; k < DEPTH; k++) free_desc(k);
        send(2, 0, 0, -1);
        check(stalled && wr_count == 0, "R6 stall holds after free", stalled, 1);
        pulse_enable();
        check(!stalled && ring_idx == 2'(exp_idx), "R7 resume", stalled, 0);
        send(4, 1, 0, -1);
        read_desc(exp_idx);
        check(wr_count == 0 && sw_rd_empty, "R7 tail dropped", wr_count, 0);
        send(25, 1, 0, -1);
        read_desc(exp_idx);
        check(wr_count == 25 && sw_rd_len == 25, "R7 next frame stored", sw_rd_len, 25);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule